// File: doc/BRIEF.md
# Triple Programmable Timer Unit

This block holds three down-counting timers, all stepped by the system clock, each with its own writable reload value and its own enable. Two of them are clock generators. The baud timer makes a 50% duty square wave at sixteen times a serial baud rate, which serves as a receiver oversampling clock. The line timer makes a 50% duty square wave that serves as a serial line clock. The third timer has no output pin. It raises a periodic tick that an operating system uses as its time base.

Software programs the unit through a plain write strobe with a two-bit address and a data word. A changed reload value does not cut into the phase that is in progress. It takes effect at the next terminal count, so the clock outputs never show a truncated half period. Each timer gives a one-cycle interrupt request. For the two clock generators this request comes once per full output period. For the tick timer it comes on every terminal count.

The reset reload values come from the clock frequency parameter, so the default clocks appear as soon as the timers are enabled. The write port has no back-pressure: every write is accepted in the cycle it is presented.

Top module: `tri_timer_unit`

## Requirements
- R1: After reset all three timers are disabled, both clock outputs are low and all three interrupt requests are low. They stay that way until an enable is written.
- R2: A write with `wr_en_i` high is decoded by `wr_addr_i`. Address 0 loads the baud timer reload, address 1 the line timer reload, address 2 the tick timer reload, and address 3 loads the enables from data bits 0 (baud), 1 (line) and 2 (tick). Each write changes only the register it addresses.
- R3: With a reload value R of 1 or more, an enabled clock timer holds its output high for exactly R cycles and then low for exactly R cycles, giving a period of 2R cycles.
- R4: A reload value of 0 behaves as 1: the output toggles on every cycle.
- R5: Each clock timer raises its interrupt request for exactly one cycle per full output period, in the cycle in which its output first reads low.
- R6: The tick timer has no clock output. When enabled, it raises its interrupt request for one cycle every R cycles, where R is its reload value (0 behaves as 1).
- R7: A reload write does not change the count in progress. The new value governs only the phases that follow the next terminal count.
- R8: Clearing a timer's enable freezes its count and forces its output low from the second cycle after the write. No interrupt request is raised while the timer is disabled. After re-enabling, counting resumes from the frozen count, and the output rises R cycles after the enable write that follows a disable issued in the first high cycle.
- R9: The reset reload values are CLK_HZ/(32*BAUD_HZ) for the baud timer, CLK_HZ/(2*LINE_HZ) for the line timer and CLK_HZ/TICK_HZ for the tick timer, each computed with integer division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; every timer counts on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0..2 reloads, 3 enables) |
| wr_data_i | input | CNT_W | Write data |
| baud_clk_o | output | 1 | Square wave at sixteen times the baud rate |
| line_clk_o | output | 1 | Square wave used as the serial line clock |
| irq_o | output | 3 | One-cycle interrupt requests: bit 0 baud, bit 1 line, bit 2 tick |

## Verification
The bench builds the unit with CLK_HZ = 3,072,000, BAUD_HZ = 9600, LINE_HZ = 50,000 and TICK_HZ = 100. These values give reset reloads of 10, 30 and 30,720 cycles, so the default baud and line clocks and a full 10 ms tick interval can all be measured cycle by cycle within the run. Because the counters are then short, the bench can sweep every reload value from 0 to 12 on every timer. It can also place a reload write and a disable at a known cycle inside a phase and predict the exact phase lengths and resume delay that follow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int NUM_TMR = 3;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_BAUD = 2'd0,
    SEL_LINE = 2'd1,
    SEL_TICK = 2'd2,
    SEL_EN   = 2'd3
  } tmr_sel_e;

  localparam int IDX_BAUD = 0;
  localparam int IDX_LINE = 1;
  localparam int IDX_TICK = 2;

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [CNT_W-1:0]      wr_data_i,
  output logic [NUM_TMR-1:0]    en_o,
  output logic [NUM_TMR-1:0]    ld_we_o,
  output logic [CNT_W-1:0]      ld_val_o
);

  logic [NUM_TMR-1:0] en_q;
  logic               en_wr;

  assign en_wr = wr_en_i && (wr_addr_i == SEL_EN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (en_wr) begin
      en_q <= wr_data_i[NUM_TMR-1:0];
    end
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
    assign ld_we_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end

  assign en_o     = en_q;
  assign ld_val_o = wr_data_i;

  // R2
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == SEL_EN) |=> $stable(en_o));

  // R2
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_we_o));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int              CNT_W      = 32,
  parameter logic [CNT_W-1:0] RST_RELOAD = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_we_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic             term_o
);

  localparam logic [CNT_W-1:0] RST_CNT =
    (RST_RELOAD == '0) ? '0 : RST_RELOAD - 1'b1;

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] start_val;
  logic             at_zero;

  assign at_zero   = (cnt_q == '0);
  assign start_val = (reload_q == '0) ? '0 : reload_q - 1'b1;
  assign term_o    = en_i && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RST_RELOAD;
    end else if (ld_we_i) begin
      reload_q <= ld_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_CNT;
    end else if (en_i) begin
      if (at_zero) cnt_q <= start_val;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));

  // R7
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic term_i,
  output logic wave_o,
  output logic irq_o
);

  logic wave_q;
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= term_i && wave_q;
      if (!en_i)       wave_q <= 1'b0;
      else if (term_i) wave_q <= ~wave_q;
    end
  end

  assign wave_o = wave_q;
  assign irq_o  = irq_q;

  // R5
  irq_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $fell(wave_o));

  // R8
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !wave_o);

  // R3
  hold_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !term_i) |=> $stable(wave_o));

endmodule

// File: rtl/tri_timer_unit.sv
module tri_timer_unit
  import tmr_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 48_000_000,
  parameter longint unsigned BAUD_HZ = 9600,
  parameter longint unsigned LINE_HZ = 50_000,
  parameter longint unsigned TICK_HZ = 100,
  parameter int              CNT_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              baud_clk_o,
  output logic              line_clk_o,
  output logic [2:0]        irq_o
);

  localparam logic [CNT_W-1:0] RL_BAUD = CNT_W'(CLK_HZ / (32 * BAUD_HZ));
  localparam logic [CNT_W-1:0] RL_LINE = CNT_W'(CLK_HZ / (2 * LINE_HZ));
  localparam logic [CNT_W-1:0] RL_TICK = CNT_W'(CLK_HZ / TICK_HZ);

  logic [NUM_TMR-1:0] en;
  logic [NUM_TMR-1:0] ld_we;
  logic [CNT_W-1:0]   ld_val;
  logic [NUM_TMR-1:0] term;
  logic [NUM_TMR-1:0] irq;
  logic [1:0]         waves;

  tmr_regif #(.CNT_W(CNT_W)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .en_o     (en),
    .ld_we_o  (ld_we),
    .ld_val_o (ld_val)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam logic [CNT_W-1:0] RL_RST =
      (i == IDX_BAUD) ? RL_BAUD : (i == IDX_LINE) ? RL_LINE : RL_TICK;

    tmr_counter #(.CNT_W(CNT_W), .RST_RELOAD(RL_RST)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en[i]),
      .ld_we_i (ld_we[i]),
      .ld_val_i(ld_val),
      .term_o  (term[i])
    );

    if (i < 2) begin : g_wave
      tmr_wavegen u_wave (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en[i]),
        .term_i(term[i]),
        .wave_o(waves[i]),
        .irq_o (irq[i])
      );
    end else begin : g_tick
      logic tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tick_q <= 1'b0;
        else         tick_q <= term[i];
      end
      assign irq[i] = tick_q;

      // R6
      tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq[i] |-> $past(en[i]));
    end
  end

  assign baud_clk_o = waves[IDX_BAUD];
  assign line_clk_o = waves[IDX_LINE];
  assign irq_o      = irq;

  // R8
  quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en[IDX_BAUD] |=> !irq_o[IDX_BAUD]);

endmodule

// File: tb/tri_timer_unit_bench.sv
module tri_timer_unit_bench;

  localparam longint unsigned CLK_HZ  = 3_072_000;
  localparam longint unsigned BAUD_HZ = 9600;
  localparam longint unsigned LINE_HZ = 50_000;
  localparam longint unsigned TICK_HZ = 100;
  localparam int              CNT_W   = 32;
  localparam int EXP_BAUD = int'(CLK_HZ / (32 * BAUD_HZ));
  localparam int EXP_LINE = int'(CLK_HZ / (2 * LINE_HZ));
  localparam int EXP_TICK = int'(CLK_HZ / TICK_HZ);
  localparam int WDOG     = 190_000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             baud_clk, line_clk;
  logic [2:0]       irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  tri_timer_unit #(
    .CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ), .LINE_HZ(LINE_HZ),
    .TICK_HZ(TICK_HZ), .CNT_W(CNT_W)
  ) u_tri_timer_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .baud_clk_o(baud_clk), .line_clk_o(line_clk),
    .irq_o(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic wv(input int ch);
    return (ch == 0) ? baud_clk : line_clk;
  endfunction

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // wait for a terminal count after the last write, then for a rising edge
  task automatic settle(input int ch);
    logic cur;
    cur = wv(ch);
    while (wv(ch) == cur) @(negedge clk);
    while (wv(ch)) @(negedge clk);
    while (!wv(ch)) @(negedge clk);
  endtask

  // starts at the first negedge with the output high
  task automatic measure_wave(input int ch, input int r, input string req);
    int h, l, ic;
    h = 0; l = 0; ic = 0;
    while (wv(ch)) begin h++; ic += int'(irq[ch]); @(negedge clk); end
    while (!wv(ch)) begin l++; ic += int'(irq[ch]); @(negedge clk); end
    chk({req, " high cycles"}, h, r);
    chk({req, " low cycles"}, l, r);
    chk("R5 irq pulses per period", ic, 1);
  endtask

  task automatic measure_tick(input int r, input string req);
    int n;
    while (!irq[2]) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!irq[2]) begin n++; @(negedge clk); end
    chk(req, n, r);
  endtask

  initial begin
    int h, l, n, lowbad, irqbad, bt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 baud low", baud_clk, 0);
    chk("R1 line low", line_clk, 0);
    chk("R1 irq low", irq, 0);
    repeat (50) @(negedge clk);
    chk("R1 stays idle", {baud_clk, line_clk, irq}, 0);

    // R9 defaults
    wr(2'd3, 7);
    settle(0); measure_wave(0, EXP_BAUD, "R9 baud default");
    settle(1); measure_wave(1, EXP_LINE, "R9 line default");
    measure_tick(EXP_TICK, "R9 tick default");

    // R3 sweeps over both clock timers
    for (int ch = 0; ch < 2; ch++) begin
      for (int r = 1; r <= 12; r++) begin
        wr(2'(ch), r);
        settle(ch);
        measure_wave(ch, r, "R3");
      end
    end

    // R6 tick sweep
    for (int r = 1; r <= 12; r++) begin
      wr(2'd2, r);
      while (!irq[2]) @(negedge clk);
      @(negedge clk);
      measure_tick(r, "R6 tick interval");
    end
    // R4 zero reload on all timers
    wr(2'd0, 0); settle(0); measure_wave(0, 1, "R4 baud zero");
    wr(2'd1, 0); settle(1); measure_wave(1, 1, "R4 line zero");
    wr(2'd2, 0);
    while (!irq[2]) @(negedge clk);
    @(negedge clk);
    measure_tick(1, "R4 tick zero");

    // R7 reload written mid-phase
    wr(2'd0, 6); settle(0); measure_wave(0, 6, "R7 setup");
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 3;
    h = 0;
    while (baud_clk) begin h++; @(negedge clk); wr_en = 1'b0; end
    chk("R7 current phase keeps old length", h, 6);
    l = 0;
    while (!baud_clk) begin l++; @(negedge clk); end
    chk("R7 next phase uses new length", l, 3);
    measure_wave(0, 3, "R7 after change");

    // R8 disable in first high cycle, then resume
    wr(2'd0, 8); settle(0); measure_wave(0, 8, "R8 setup");
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 3'b110;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 output still high one cycle after write", baud_clk, 1);
    lowbad = 0; irqbad = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      lowbad += int'(baud_clk);
      irqbad += int'(irq[0]);
    end
    chk("R8 output low while disabled", lowbad, 0);
    chk("R8 no irq while disabled", irqbad, 0);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 3'b111;
    n = 0;
    do begin @(negedge clk); wr_en = 1'b0; n++; end while (!baud_clk);
    chk("R8 resume from frozen count", n, 8);
    measure_wave(0, 8, "R8 after resume");

    // R2 enable bits select timers independently
    wr(2'd1, 4);
    wr(2'd3, 3'b010);
    repeat (3) @(negedge clk);
    bt = 0; n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      bt += int'(baud_clk) + int'(irq[0]) + int'(irq[2]);
      n += int'(line_clk);
    end
    chk("R2 only bit 1 timer runs", bt, 0);
    chk("R2 line timer runs", n, 20);
    wr(2'd0, 5);
    settle(1);
    measure_wave(1, 4, "R2 line reload untouched by baud write");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule